// File: doc/BRIEF.md
# DDR SDRAM Command Protocol Monitor

This block watches the command pins of a DDR SDRAM interface on every rising clock edge and turns the chip-select, row-strobe, column-strobe and write-enable levels into a command code. It keeps a model of the protocol state that matters for legality: which of the banks hold an open row, whether a read or write burst is still running and whether that burst carries auto precharge, and whether the device sits in self refresh. It also keeps a copy of the last words written to the base and extended mode registers.

Each command is judged against the state that existed before its clock edge. The first protocol violation raises a sticky flag and records a reason code. Both stay until reset, so a long run can be inspected after the fact. The block is meant to sit beside a memory controller, in simulation or on silicon, as a passive observer. It drives nothing back onto the memory bus.

The burst length in clock cycles is a parameter (default 2). An auto-precharge burst closes its bank at the edge where the burst ends. If a new READ or WRITE replaces it earlier, the bank closes at the edge of that replacing command.

Top module: `ddr_cmd_monitor`

## Requirements
- R1: After reset, every bank is idle, `cmd_code` is 0, both mode words are 0, and `illegal_seen` and `illegal_reason` are 0.
- R2: The pins {cs_n,ras_n,cas_n,we_n} are decoded at each edge and the code appears on `cmd_code` after that edge. The codes are: 0111 gives 0 (NOP), 0011 gives 1 (ACTIVE), 0101 gives 2 (READ), 0100 gives 3 (WRITE), 0110 gives 4 (BURST TERMINATE), 0010 gives 5 (PRECHARGE), 0000 gives 8 (LOAD MODE). With cs_n high the code is 0, whatever the other pins are.
- R3: ACTIVE marks bank `ba` open. ACTIVE to a bank that is already open sets reason 1, and the bank stays open.
- R4: READ or WRITE to an idle bank sets reason 2 and starts no burst.
- R5: PRECHARGE with addr[10] low closes only bank `ba`. With addr[10] high it closes every bank and ignores `ba`.
- R6: A READ or WRITE with addr[10] high to an open bank closes that bank BURST_CYCLES edges after the command edge. If another READ or WRITE arrives first, the bank closes at the edge of that new command.
- R7: BURST TERMINATE during a running read without auto precharge ends the burst, leaves the row open and flags nothing. With no burst, or during a write burst, it sets reason 4. During a read with auto precharge it sets reason 5.
- R8: Pins 0001 give code 6 (AUTO REFRESH) when cke is high and code 7 (SELF REFRESH) when cke is low. Either one issued while any bank is open sets reason 3.
- R9: After SELF REFRESH, every input except cke is ignored: `cmd_code` reads 0 and no bank or mode word changes. The first edge that samples cke high leaves self refresh, and the command at that edge is also ignored.
- R10: LOAD MODE with ba=00 stores addr in `mode_word`. With ba=10 (ba[1]=1, ba[0]=0) it stores addr in `ext_mode_word`. Any other ba value changes neither word. `dll_disabled` is bit 0 of the extended word and `drive_reduced` is bit 1.
- R11: The first violation sets `illegal_seen` and stores its reason code. Later violations change neither output, and only reset clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory command clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable |
| ba | input | BA_W (2) | Bank address |
| addr | input | ADDR_W (13) | Address bus / op-code |
| cmd_code | output | 4 | Decoded command of the last edge |
| bank_open | output | NUM_BANKS (4) | One bit per bank, 1 = row open |
| mode_word | output | ADDR_W | Last base mode register op-code |
| ext_mode_word | output | ADDR_W | Last extended mode register op-code |
| dll_disabled | output | 1 | Extended word bit 0 |
| drive_reduced | output | 1 | Extended word bit 1 |
| illegal_seen | output | 1 | Sticky violation flag |
| illegal_reason | output | 3 | Reason code of the first violation |

## Verification
An auto-precharge burst can end at the same edge where a new command changes the bank state. In that case one edge must close one bank and open another, or close the old burst's bank while it starts a new burst. The bench provokes the first case: a WRITE with auto precharge to bank 2, followed at the ending edge by ACTIVE to bank 1. It provokes the second case with a READ with auto precharge that is replaced one edge later by a READ to a different bank. Each is judged by the `bank_open` pattern after that single edge and by `illegal_seen` staying clear.

// File: rtl/ddr_mon_pkg.sv
// Shared command and violation encodings for the DDR command monitor.
package ddr_mon_pkg;

    typedef enum logic [3:0] {
        CMD_NOP   = 4'd0,
        CMD_ACT   = 4'd1,
        CMD_READ  = 4'd2,
        CMD_WRITE = 4'd3,
        CMD_BST   = 4'd4,
        CMD_PRE   = 4'd5,
        CMD_AREF  = 4'd6,
        CMD_SREF  = 4'd7,
        CMD_LMR   = 4'd8
    } cmd_e;

    typedef enum logic [2:0] {
        ERR_NONE     = 3'd0,
        ERR_ACT_OPEN = 3'd1,
        ERR_RW_IDLE  = 3'd2,
        ERR_REF_BUSY = 3'd3,
        ERR_BST_NONE = 3'd4,
        ERR_BST_AP   = 3'd5
    } err_e;

endpackage

// File: rtl/ddr_cmd_decode.sv
// Pin-level command decoder.
// Turns the four strobe levels plus cke into a command code.
// Assumes: the caller passes self_ref high while the device sleeps, and the
// decoder then reports NOP so that no command takes effect.
module ddr_cmd_decode
    import ddr_mon_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic cke,
    input  logic self_ref,
    output cmd_e cmd
);

    // Map the strobe pattern to a command; deselect and sleep give NOP.
    always_comb begin
        cmd = CMD_NOP;
        if (!self_ref && !cs_n) begin
            case ({ras_n, cas_n, we_n})
                3'b011:  cmd = CMD_ACT;
                3'b101:  cmd = CMD_READ;
                3'b100:  cmd = CMD_WRITE;
                3'b110:  cmd = CMD_BST;
                3'b010:  cmd = CMD_PRE;
                3'b001:  cmd = cke ? CMD_AREF : CMD_SREF;
                3'b000:  cmd = CMD_LMR;
                default: cmd = CMD_NOP;
            endcase
        end
    end

endmodule

// File: rtl/ddr_bank_tracker.sv
// Per-bank row state.
// Holds one open/idle bit per bank. Set and close requests come as masks.
// Assumes: a set request only targets a bank that was idle, so it never
// collides with a close request on the same bank.
module ddr_bank_tracker #(
    parameter int NUM_BANKS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_BANKS-1:0] open_req,
    input  logic [NUM_BANKS-1:0] close_req,
    output logic [NUM_BANKS-1:0] bank_open
);

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        // Update the state bit of one bank; a close wins over a set.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bank_open[g] <= 1'b0;
            end else if (close_req[g]) begin
                bank_open[g] <= 1'b0;
            end else if (open_req[g]) begin
                bank_open[g] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/ddr_burst_tracker.sv
// Single-slot burst tracker.
// Remembers the most recent READ/WRITE burst: its kind, its bank, whether it
// carries auto precharge, and how many edges remain.
// Assumes: start and stop never arrive together. A new start replaces the
// running burst, and an auto-precharge burst that ends or is replaced raises
// ap_close for its bank at that edge.
module ddr_burst_tracker #(
    parameter int BA_W         = 2,
    parameter int BURST_CYCLES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            start_read,
    input  logic            start_ap,
    input  logic [BA_W-1:0] start_bank,
    input  logic            stop,
    output logic            active,
    output logic            is_read,
    output logic            auto_pre,
    output logic            ap_close,
    output logic [BA_W-1:0] ap_bank
);

    localparam int CNT_W = $clog2(BURST_CYCLES + 1);

    logic [CNT_W-1:0] remain_q;
    logic             last_edge;

    // The running burst finishes at this edge.
    always_comb last_edge = active && (remain_q == CNT_W'(1));

    // An auto-precharge burst leaves, by natural end or by replacement.
    always_comb ap_close = active && auto_pre && (start || last_edge);

    // Bank closed by the auto-precharge burst.
    always_comb ap_bank = start_bank_q;

    logic [BA_W-1:0] start_bank_q;

    // Load, count down or drop the burst slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active       <= 1'b0;
            is_read      <= 1'b0;
            auto_pre     <= 1'b0;
            start_bank_q <= '0;
            remain_q     <= '0;
        end else if (start) begin
            active       <= 1'b1;
            is_read      <= start_read;
            auto_pre     <= start_ap;
            start_bank_q <= start_bank;
            remain_q     <= CNT_W'(BURST_CYCLES);
        end else if (stop) begin
            active   <= 1'b0;
            remain_q <= '0;
        end else if (active) begin
            active   <= !last_edge;
            remain_q <= remain_q - CNT_W'(1);
        end
    end

endmodule

// File: rtl/ddr_cmd_monitor.sv
// DDR SDRAM command protocol monitor (top).
// Decodes each sampled command, judges it against bank and burst state,
// keeps the mode register words and a sticky first-violation record.
// Assumes: pins are sampled on the rising edge; synchronous active-low reset;
// the burst duration in clock cycles is fixed by BURST_CYCLES.
module ddr_cmd_monitor
    import ddr_mon_pkg::*;
#(
    parameter  int NUM_BANKS    = 4,
    parameter  int ADDR_W       = 13,
    parameter  int AP_BIT       = 10,
    parameter  int BURST_CYCLES = 2,
    localparam int BA_W         = $clog2(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_n,
    input  logic                 ras_n,
    input  logic                 cas_n,
    input  logic                 we_n,
    input  logic                 cke,
    input  logic [BA_W-1:0]      ba,
    input  logic [ADDR_W-1:0]    addr,
    output logic [3:0]           cmd_code,
    output logic [NUM_BANKS-1:0] bank_open,
    output logic [ADDR_W-1:0]    mode_word,
    output logic [ADDR_W-1:0]    ext_mode_word,
    output logic                 dll_disabled,
    output logic                 drive_reduced,
    output logic                 illegal_seen,
    output logic [2:0]           illegal_reason
);

    localparam logic [BA_W-1:0] BA_BASE = BA_W'(0);
    localparam logic [BA_W-1:0] BA_EXT  = BA_W'(2);

    cmd_e                 cmd;
    err_e                 err;
    logic                 sr_q;
    logic                 sr_enter;
    logic                 sel_open;
    logic [NUM_BANKS-1:0] sel_mask;
    logic [NUM_BANKS-1:0] open_req;
    logic [NUM_BANKS-1:0] close_req;
    logic [NUM_BANKS-1:0] ap_mask;
    logic                 b_start;
    logic                 b_stop;
    logic                 b_active;
    logic                 b_is_read;
    logic                 b_ap;
    logic                 b_ap_close;
    logic [BA_W-1:0]      b_ap_bank;

    ddr_cmd_decode u_decode (
        .cs_n     (cs_n),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .we_n     (we_n),
        .cke      (cke),
        .self_ref (sr_q),
        .cmd      (cmd)
    );

    // One-hot mask of the addressed bank and its current state.
    always_comb begin
        sel_mask     = '0;
        sel_mask[ba] = 1'b1;
        sel_open     = bank_open[ba];
    end

    // Mask of the bank released by an ending auto-precharge burst.
    always_comb begin
        ap_mask            = '0;
        ap_mask[b_ap_bank] = b_ap_close;
    end

    // Judge the command against state before the edge and form requests.
    always_comb begin
        err       = ERR_NONE;
        open_req  = '0;
        close_req = ap_mask;
        b_start   = 1'b0;
        b_stop    = 1'b0;
        sr_enter  = 1'b0;
        case (cmd)
            CMD_ACT: begin
                if (sel_open) err = ERR_ACT_OPEN;
                else          open_req = sel_mask;
            end
            CMD_READ, CMD_WRITE: begin
                if (!sel_open) err = ERR_RW_IDLE;
                else           b_start = 1'b1;
            end
            CMD_BST: begin
                if (!(b_active && b_is_read)) err = ERR_BST_NONE;
                else if (b_ap)                err = ERR_BST_AP;
                else                          b_stop = 1'b1;
            end
            CMD_PRE: begin
                close_req = ap_mask | (addr[AP_BIT] ? {NUM_BANKS{1'b1}} : sel_mask);
            end
            CMD_AREF, CMD_SREF: begin
                if (|bank_open) err = ERR_REF_BUSY;
                sr_enter = (cmd == CMD_SREF);
            end
            default: ;
        endcase
    end

    ddr_bank_tracker #(.NUM_BANKS(NUM_BANKS)) u_banks (
        .clk       (clk),
        .rst_n     (rst_n),
        .open_req  (open_req),
        .close_req (close_req),
        .bank_open (bank_open)
    );

    ddr_burst_tracker #(.BA_W(BA_W), .BURST_CYCLES(BURST_CYCLES)) u_burst (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (b_start),
        .start_read (cmd == CMD_READ),
        .start_ap   (addr[AP_BIT]),
        .start_bank (ba),
        .stop       (b_stop),
        .active     (b_active),
        .is_read    (b_is_read),
        .auto_pre   (b_ap),
        .ap_close   (b_ap_close),
        .ap_bank    (b_ap_bank)
    );

    // Self-refresh state: enter on the sleep command, leave when cke is seen high.
    always_ff @(posedge clk) begin
        if (!rst_n)    sr_q <= 1'b0;
        else if (sr_q) sr_q <= !cke;
        else           sr_q <= sr_enter;
    end

    // Register the decoded command for the output.
    always_ff @(posedge clk) begin
        if (!rst_n) cmd_code <= 4'(CMD_NOP);
        else        cmd_code <= 4'(cmd);
    end

    // Capture mode register op-codes by bank-address selector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_word     <= '0;
            ext_mode_word <= '0;
        end else if (cmd == CMD_LMR) begin
            if (ba == BA_BASE) mode_word     <= addr;
            if (ba == BA_EXT)  ext_mode_word <= addr;
        end
    end

    always_comb dll_disabled  = ext_mode_word[0];
    always_comb drive_reduced = ext_mode_word[1];

    // Record the first violation and hold it until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            illegal_seen   <= 1'b0;
            illegal_reason <= 3'(ERR_NONE);
        end else if (!illegal_seen && err != ERR_NONE) begin
            illegal_seen   <= 1'b1;
            illegal_reason <= 3'(err);
        end
    end

endmodule

// File: rtl/ddr_cmd_monitor_chk.sv
// Property checker for ddr_cmd_monitor, bound to every instance.
// Assumes: the same parameters as the monitor and its internal sleep bit.
module ddr_cmd_monitor_chk #(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 13,
    parameter int AP_BIT    = 10,
    parameter int BA_W      = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cs_n,
    input logic                 ras_n,
    input logic                 cas_n,
    input logic                 we_n,
    input logic                 cke,
    input logic [BA_W-1:0]      ba,
    input logic [ADDR_W-1:0]    addr,
    input logic [3:0]           cmd_code,
    input logic [NUM_BANKS-1:0] bank_open,
    input logic [ADDR_W-1:0]    mode_word,
    input logic [ADDR_W-1:0]    ext_mode_word,
    input logic                 illegal_seen,
    input logic [2:0]           illegal_reason,
    input logic                 self_ref
);

    a_r11_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_seen |=> illegal_seen);

    a_r11_reason_held: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_seen |=> $stable(illegal_reason));

    a_r11_flag_has_reason: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_seen |-> (illegal_reason != 3'd0));

    a_r2_deselect_is_nop: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && !self_ref) |=> (cmd_code == 4'd0));

    a_r9_sleep_is_nop: assert property (@(posedge clk) disable iff (!rst_n)
        self_ref |=> (cmd_code == 4'd0));

    a_r9_sleep_keeps_modes: assert property (@(posedge clk) disable iff (!rst_n)
        self_ref |=> ($stable(mode_word) && $stable(ext_mode_word)));

    a_r9_wake_on_cke: assert property (@(posedge clk) disable iff (!rst_n)
        (self_ref && cke) |=> !self_ref);

    a_r9_stay_asleep: assert property (@(posedge clk) disable iff (!rst_n)
        (self_ref && !cke) |=> self_ref);

    a_r5_precharge_all: assert property (@(posedge clk) disable iff (!rst_n)
        (!self_ref && !cs_n && !ras_n && cas_n && !we_n && addr[AP_BIT])
        |=> (bank_open == '0));

    a_r10_base_mode_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!self_ref && !cs_n && !ras_n && !cas_n && !we_n && ba == BA_W'(0))
        |=> (mode_word == $past(addr)));

endmodule

bind ddr_cmd_monitor ddr_cmd_monitor_chk #(
    .NUM_BANKS (NUM_BANKS),
    .ADDR_W    (ADDR_W),
    .AP_BIT    (AP_BIT),
    .BA_W      (BA_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cs_n           (cs_n),
    .ras_n          (ras_n),
    .cas_n          (cas_n),
    .we_n           (we_n),
    .cke            (cke),
    .ba             (ba),
    .addr           (addr),
    .cmd_code       (cmd_code),
    .bank_open      (bank_open),
    .mode_word      (mode_word),
    .ext_mode_word  (ext_mode_word),
    .illegal_seen   (illegal_seen),
    .illegal_reason (illegal_reason),
    .self_ref       (sr_q)
);

// File: tb/ddr_cmd_monitor_tb.sv
`timescale 1ns/1ps
// Self-checking bench: a vector table walk, then directed corner cases.
module ddr_cmd_monitor_tb;

    localparam logic [3:0] P_NOP = 4'b0111;
    localparam logic [3:0] P_DES = 4'b1000;
    localparam logic [3:0] P_ACT = 4'b0011;
    localparam logic [3:0] P_RD  = 4'b0101;
    localparam logic [3:0] P_WR  = 4'b0100;
    localparam logic [3:0] P_BST = 4'b0110;
    localparam logic [3:0] P_PRE = 4'b0010;
    localparam logic [3:0] P_REF = 4'b0001;
    localparam logic [3:0] P_LMR = 4'b0000;
    localparam logic [12:0] AP   = 13'h0400;

    typedef struct packed {
        logic [3:0]  pins;
        logic        ck;
        logic [1:0]  bk;
        logic [12:0] ad;
        logic [3:0]  ecmd;
        logic [3:0]  eopen;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{P_NOP, 1'b1, 2'd0, 13'h0000, 4'd0, 4'b0000},
        '{P_ACT, 1'b1, 2'd0, 13'h0011, 4'd1, 4'b0001},
        '{P_ACT, 1'b1, 2'd2, 13'h0022, 4'd1, 4'b0101},
        '{P_RD,  1'b1, 2'd0, 13'h0003, 4'd2, 4'b0101},
        '{P_BST, 1'b1, 2'd0, 13'h0000, 4'd4, 4'b0101},
        '{P_WR,  1'b1, 2'd2, AP,       4'd3, 4'b0101},
        '{P_NOP, 1'b1, 2'd0, 13'h0000, 4'd0, 4'b0101},
        '{P_ACT, 1'b1, 2'd1, 13'h0044, 4'd1, 4'b0011},
        '{P_DES, 1'b1, 2'd3, 13'h1fff, 4'd0, 4'b0011},
        '{P_PRE, 1'b1, 2'd0, 13'h0000, 4'd5, 4'b0010},
        '{P_ACT, 1'b1, 2'd3, 13'h0055, 4'd1, 4'b1010},
        '{P_ACT, 1'b1, 2'd0, 13'h0066, 4'd1, 4'b1011},
        '{P_PRE, 1'b1, 2'd3, AP,       4'd5, 4'b0000},
        '{P_REF, 1'b1, 2'd0, 13'h0000, 4'd6, 4'b0000},
        '{P_LMR, 1'b1, 2'd0, 13'h0123, 4'd8, 4'b0000},
        '{P_LMR, 1'b1, 2'd2, 13'h0002, 4'd8, 4'b0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic        cke = 1'b1;
    logic [1:0]  ba = '0;
    logic [12:0] addr = '0;
    logic [3:0]  cmd_code;
    logic [3:0]  bank_open;
    logic [12:0] mode_word, ext_mode_word;
    logic        dll_disabled, drive_reduced, illegal_seen;
    logic [2:0]  illegal_reason;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ddr_cmd_monitor u_dut (
        .clk (clk), .rst_n (rst_n),
        .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n),
        .cke (cke), .ba (ba), .addr (addr),
        .cmd_code (cmd_code), .bank_open (bank_open),
        .mode_word (mode_word), .ext_mode_word (ext_mode_word),
        .dll_disabled (dll_disabled), .drive_reduced (drive_reduced),
        .illegal_seen (illegal_seen), .illegal_reason (illegal_reason)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Drive one command at a falling edge; return after the next falling edge.
    task automatic apply(input logic [3:0] p, input logic k, input logic [1:0] b, input logic [12:0] a);
        {cs_n, ras_n, cas_n, we_n} = p;
        cke  = k;
        ba   = b;
        addr = a;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        {cs_n, ras_n, cas_n, we_n} = P_NOP;
        cke = 1'b1; ba = '0; addr = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        // R1: state right after reset
        check("R1 cmd_code", cmd_code, 0);
        check("R1 bank_open", bank_open, 0);
        check("R1 mode words", {mode_word, ext_mode_word}, 0);
        check("R1 illegal", {illegal_seen, illegal_reason}, 0);

        // Table walk: legal traffic, including the burst-end/ACTIVE overlap (R6)
        for (int i = 0; i < NV; i++) begin
            apply(VECS[i].pins, VECS[i].ck, VECS[i].bk, VECS[i].ad);
            check($sformatf("R2 cmd_code step %0d", i), cmd_code, VECS[i].ecmd);
            check($sformatf("R5 bank_open step %0d", i), bank_open, VECS[i].eopen);
            check($sformatf("R11 no violation step %0d", i), {illegal_seen, illegal_reason}, 0);
        end
        check("R10 base mode word", mode_word, 13'h0123);
        check("R10 ext mode word", ext_mode_word, 13'h0002);
        check("R10 drive_reduced", drive_reduced, 1);
        check("R10 dll_disabled", dll_disabled, 0);
        apply(P_LMR, 1'b1, 2'd2, 13'h0001);
        check("R10 dll_disabled set", {dll_disabled, drive_reduced}, 2'b10);
        // R10: reserved selectors 01 and 11 are ignored
        apply(P_LMR, 1'b1, 2'd1, 13'h0aaa);
        apply(P_LMR, 1'b1, 2'd3, 13'h0bbb);
        check("R10 reserved ba ignored", {mode_word, ext_mode_word}, {13'h0123, 13'h0001});

        // R3 and R11: ACTIVE to an open bank, then a second violation
        do_reset();
        apply(P_ACT, 1'b1, 2'd1, 13'h0);
        apply(P_ACT, 1'b1, 2'd1, 13'h0);
        check("R3 act-open reason", {illegal_seen, illegal_reason}, {1'b1, 3'd1});
        check("R3 bank stays open", bank_open, 4'b0010);
        apply(P_RD, 1'b1, 2'd3, 13'h0);
        check("R11 first reason kept", {illegal_seen, illegal_reason}, {1'b1, 3'd1});

        // R4: READ to an idle bank
        do_reset();
        apply(P_RD, 1'b1, 2'd1, 13'h0);
        check("R4 read idle reason", {illegal_seen, illegal_reason}, {1'b1, 3'd2});
        check("R4 read idle code", cmd_code, 2);

        // R7: BURST TERMINATE with nothing running
        do_reset();
        apply(P_BST, 1'b1, 2'd0, 13'h0);
        check("R7 bst no burst", {illegal_seen, illegal_reason}, {1'b1, 3'd4});

        // R7: BURST TERMINATE during a write burst
        do_reset();
        apply(P_ACT, 1'b1, 2'd0, 13'h0);
        apply(P_WR, 1'b1, 2'd0, 13'h0);
        apply(P_BST, 1'b1, 2'd0, 13'h0);
        check("R7 bst during write", {illegal_seen, illegal_reason}, {1'b1, 3'd4});

        // R7 and R6: BURST TERMINATE on an auto-precharge read, then bank close
        do_reset();
        apply(P_ACT, 1'b1, 2'd0, 13'h0);
        apply(P_RD, 1'b1, 2'd0, AP);
        apply(P_BST, 1'b1, 2'd0, 13'h0);
        check("R7 bst auto-precharge", {illegal_seen, illegal_reason}, {1'b1, 3'd5});
        check("R6 open mid-burst", bank_open, 4'b0001);
        apply(P_NOP, 1'b1, 2'd0, 13'h0);
        check("R6 closed at burst end", bank_open, 4'b0000);

        // R6: auto-precharge read replaced by a new READ; R7 legal terminate
        do_reset();
        apply(P_ACT, 1'b1, 2'd0, 13'h0);
        apply(P_ACT, 1'b1, 2'd1, 13'h0);
        apply(P_RD, 1'b1, 2'd0, AP);
        apply(P_RD, 1'b1, 2'd1, 13'h0);
        check("R6 replaced burst closes", bank_open, 4'b0010);
        apply(P_BST, 1'b1, 2'd0, 13'h0);
        check("R7 legal terminate", {illegal_seen, bank_open}, {1'b0, 4'b0010});

        // R8: refresh with a bank open
        do_reset();
        apply(P_ACT, 1'b1, 2'd2, 13'h0);
        apply(P_REF, 1'b1, 2'd0, 13'h0);
        check("R8 refresh busy", {illegal_seen, illegal_reason}, {1'b1, 3'd3});
        check("R8 auto refresh code", cmd_code, 6);

        // R9: self refresh ignores commands until cke returns
        do_reset();
        apply(P_REF, 1'b0, 2'd0, 13'h0);
        check("R9 sleep code", {cmd_code, illegal_seen}, {4'd7, 1'b0});
        apply(P_ACT, 1'b0, 2'd0, 13'h0);
        check("R9 act ignored", {cmd_code, bank_open}, {4'd0, 4'b0000});
        apply(P_LMR, 1'b0, 2'd0, 13'h0fff);
        check("R9 lmr ignored", mode_word, 0);
        apply(P_ACT, 1'b1, 2'd0, 13'h0);
        check("R9 wake edge ignored", {cmd_code, bank_open}, {4'd0, 4'b0000});
        apply(P_ACT, 1'b1, 2'd0, 13'h0);
        check("R9 awake again", {cmd_code, bank_open}, {4'd1, 4'b0001});

        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung, expected completion");
            finish_run();
        end
    end

endmodule